// File: doc/BRIEF.md
# Rate-Matching Scan Serializer

This block sits between a block decompressor and the serial input of a core's scan chain. The decompressor hands it a fixed-width block in one parallel transfer. The serializer then feeds that block into the chain one bit per scan-clock cycle, starting with bit 0. The scan chain shifts faster than the compressed stream arrives. The whole block runs on the scan clock, and the slower tester rate reaches it as a periodic enable pulse. A transfer is only taken on a cycle where that pulse is high.

The serializer does not shift freely. Its scan-shift enable is high only while bits of a block are still waiting to go out. Once the last bit has left, the enable drops and the chain stalls until the next block comes in. A new block may be accepted in the cycle that sends the final bit of the current one, so a well-paced stream reaches the chain with no gap. A transfer that comes while two or more bits are still waiting is dropped and reported by a one-cycle overflow pulse.

Top module: `scan_serializer`

## Requirements
- R1: After reset, `empty` is 1 and `scan_en`, `scan_out` and `overflow` are 0.
- R2: Once a block is accepted, `scan_en` is high for exactly BLK_W consecutive cycles, starting in the cycle after acceptance. In those cycles `scan_out` presents `load_data[0]`, then `load_data[1]`, and so on up to `load_data[BLK_W-1]`.
- R3: A block is accepted on a clock edge where `load_valid` and `tester_en` are both 1 and the register is empty.
- R4: A block presented in the cycle that sends the last pending bit is accepted. Its bit 0 follows in the next cycle with no idle cycle in between.
- R5: While no bits are pending, `scan_en` is 0 and `scan_out` is 0. The chain stays stalled until a block is accepted.
- R6: A transfer presented with `tester_en` high while two or more bits are pending is dropped, and `overflow` is 1 for exactly the following cycle. The bits already in progress go on shifting unchanged.
- R7: `load_valid` is ignored on cycles where `tester_en` is 0. No data is taken and no overflow is raised.
- R8: `empty` is 1 exactly when no bits are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tester_en | input | 1 | Tester-rate enable pulse; transfers are only taken when it is high |
| load_valid | input | 1 | Decompressor offers a block |
| load_data | input | BLK_W | Decoded block; bit 0 is shifted out first |
| scan_out | output | 1 | Serial data into the scan chain |
| scan_en | output | 1 | Scan-shift enable; low stalls the chain |
| empty | output | 1 | No bits pending |
| overflow | output | 1 | One-cycle pulse: a transfer was dropped because bits were pending |

## Verification
The assertions do not assume that the upstream code respects the minimum codeword length. Instead they treat an early transfer as a legal input, check that it leads to an overflow pulse, and check that it does not disturb the drain in progress. They do assume that `load_valid` and `tester_en` are stable around the clock edge. The stimulus meets this by changing every input on the falling edge.

The stimulus covers several patterns:
- well-paced transfers spaced exactly one block apart;
- transfers that land at every other point in a drain;
- offers made while the tester enable is low;
- a long pseudo-random stretch with the enable pulsing at half rate.

This spacing puts loads in the empty state, in the last-bit cycle and in the overflow window.

// File: rtl/scan_serializer.sv
module scan_serializer #(
  parameter int BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tester_en,
  input  logic             load_valid,
  input  logic [BLK_W-1:0] load_data,
  output logic             scan_out,
  output logic             scan_en,
  output logic             empty,
  output logic             overflow
);
  localparam int CNT_W = $clog2(BLK_W + 1);

  logic [BLK_W-1:0] shreg;
  logic [CNT_W-1:0] remain;
  logic             take;
  logic             room;

  assign take = load_valid & tester_en;
  assign room = (remain <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '0;
      remain   <= '0;
      overflow <= 1'b0;
    end else begin
      overflow <= take & ~room;
      if (take && room) begin
        shreg  <= load_data;
        remain <= CNT_W'(BLK_W);
      end else if (remain != '0) begin
        shreg  <= shreg >> 1;
        remain <= remain - CNT_W'(1);
      end
    end
  end

  assign scan_en  = (remain != '0);
  assign empty    = (remain == '0);
  assign scan_out = shreg[0];
endmodule

// File: rtl/scan_serializer_chk.sv
module scan_serializer_chk #(
  parameter int BLK_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tester_en,
  input logic             load_valid,
  input logic [BLK_W-1:0] load_data,
  input logic             scan_out,
  input logic             scan_en,
  input logic             empty,
  input logic             overflow
);
  // R5
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> !scan_out);

  // R3
  load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && tester_en && empty) |=> (scan_en && !empty));

  // R6
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && $past(rst_n)) |-> $past(load_valid && tester_en && !empty));

  // R6
  ovf_keeps_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> scan_en);

  // R7
  gated_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !(load_valid && tester_en)) |=> (empty && !overflow));

  // R8
  empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty != scan_en);
endmodule

bind scan_serializer scan_serializer_chk #(.BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tester_en(tester_en), .load_valid(load_valid),
  .load_data(load_data), .scan_out(scan_out), .scan_en(scan_en),
  .empty(empty), .overflow(overflow)
);

// File: tb/test_scan_serializer.sv
module test_scan_serializer;
  localparam int B = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tester_en = 1'b0;
  logic         load_valid = 1'b0;
  logic [B-1:0] load_data = '0;
  logic         scan_out, scan_en, empty, overflow;

  int    errors = 0;
  int    checks = 0;
  string phase = "R1";

  bit q[$];
  bit exp_ovf = 1'b0;

  always #10 clk = ~clk;

  scan_serializer #(.BLK_W(B)) i_scan_serializer (
    .clk(clk), .rst_n(rst_n), .tester_en(tester_en), .load_valid(load_valid),
    .load_data(load_data), .scan_out(scan_out), .scan_en(scan_en),
    .empty(empty), .overflow(overflow)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      exp_ovf = 1'b0;
    end else begin
      int pend;
      pend = q.size();
      if (pend > 0) void'(q.pop_front());
      exp_ovf = 1'b0;
      if (load_valid && tester_en) begin
        if (pend <= 1) begin
          for (int i = 0; i < B; i++) q.push_back(load_data[i]);
        end else begin
          exp_ovf = 1'b1;
        end
      end
    end
  end

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) t=%0t actual=%0b expected=%0b", req, phase, $time, act, exp);
    end
  endtask

  task automatic compare();
    bit e_en, e_out;
    e_en  = (q.size() > 0);
    e_out = e_en ? q[0] : 1'b0;
    check1("R2 scan_en", scan_en, e_en);
    check1("R2 scan_out", scan_out, e_out);
    check1("R8 empty", empty, !e_en);
    check1("R6 overflow", overflow, exp_ovf);
  endtask

  task automatic cyc(input logic en, input logic v, input logic [B-1:0] d);
    tester_en  = en;
    load_valid = v;
    load_data  = d;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    check1("R1 empty", empty, 1'b1);
    check1("R1 scan_en", scan_en, 1'b0);
    check1("R1 scan_out", scan_out, 1'b0);
    check1("R1 overflow", overflow, 1'b0);
    rst_n = 1'b1;

    phase = "R3";
    cyc(1, 1, 4'b1011);
    check1("R3 accepted", scan_en, 1'b1);
    for (int i = 0; i < 3; i++) cyc(0, 0, '0);
    phase = "R5";
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, '0);
      check1("R5 stalled", scan_en, 1'b0);
    end

    phase = "R7";
    for (int i = 0; i < 4; i++) begin
      cyc(0, 1, 4'b1111);
      check1("R7 gated", empty, 1'b1);
    end

    phase = "R4";
    for (int k = 0; k < 4; k++) begin
      cyc(1, 1, 4'(k * 5 + 3));
      for (int i = 0; i < 3; i++) cyc(0, 0, '0);
    end
    for (int i = 0; i < 4; i++) cyc(0, 0, '0);

    phase = "R6";
    cyc(1, 1, 4'b0110);
    cyc(1, 1, 4'b1001);
    check1("R6 pulse", overflow, 1'b1);
    cyc(1, 1, 4'b1111);
    cyc(0, 0, '0);
    cyc(1, 1, 4'b0101);
    for (int i = 0; i < 6; i++) cyc(0, 0, '0);

    phase = "mixed";
    for (int i = 0; i < 2000; i++) cyc(i % 2 == 0, 1'($urandom_range(0, 2) != 0), 4'($urandom));

    phase = "R6 late";
    for (int off = 0; off < 6; off++) begin
      cyc(1, 1, 4'b1100);
      for (int i = 0; i < off; i++) cyc(0, 0, '0);
      cyc(1, 1, 4'b0011);
      for (int i = 0; i < 6; i++) cyc(0, 0, '0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule